// File: doc/BRIEF.md
# Loadable-Ratio Frequency Synthesizer Core

This block is the digital heart of a frequency synthesizer that holds an external voltage-controlled oscillator at a chosen multiple of a slow reference. It runs on one system clock. The reference clock and the oscillator output reach it as single-cycle edge strobes (`ref_tick`, `vco_tick`) produced by edge detectors upstream.

A divider with a fixed ratio turns the reference strobes into a comparison pulse. For example, a 300 kHz reference divided by 300 gives 1 kHz. A second divider, whose 14-bit ratio is loaded at run time, turns the oscillator strobes into a feedback pulse at the same rate. A loaded ratio of 9998 therefore tunes the loop to 9.998 MHz, and 10011 tunes it to 10.011 MHz. The step size equals the comparison rate.

A three-state phase/frequency comparator turns the order of the two pulses into `up` and `dn` outputs for an external loop filter. A lock detector watches how wide those outputs are in each comparison period.

Top module: `pfd_synth_core`

## Requirements
- R1: While reset is asserted, and until the first divider terminal count after it, `up`, `dn`, `locked`, `ref_pulse` and `fb_pulse` are all 0.
- R2: `ref_pulse` is high for exactly one clock after every REF_DIV-th `ref_tick`. With `ref_tick` held high it recurs every REF_DIV clocks.
- R3: `fb_pulse` is high for one clock after every N-th `vco_tick`, where N is the active ratio. After reset N is FB_DEFAULT.
- R4: A ratio captured by `ratio_load` does not shorten or stretch the feedback interval in progress. It sets the length of the interval that starts at the next feedback terminal count.
- R5: When `ref_pulse` comes k clocks before `fb_pulse`, `up` is high for exactly k clocks, starting the clock after `ref_pulse`, and `dn` stays low.
- R6: When `fb_pulse` comes k clocks before `ref_pulse`, `dn` is high for exactly k clocks, and `up` stays low.
- R7: When both pulses occur in the same clock, neither `up` nor `dn` rises.
- R8: `locked` rises after `lock_periods` consecutive comparison periods in which the width of `up` plus `dn` is at most `pulse_limit`. A `lock_periods` of 0 acts as 1.
- R9: A comparison period whose width exceeds `pulse_limit` clears `locked` and restarts the count.
- R10: The reference divider advances only on clocks with `ref_tick` high. With `ref_tick` high every other clock, the `ref_pulse` interval is 2×REF_DIV clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_tick | input | 1 | One-clock strobe per reference edge |
| vco_tick | input | 1 | One-clock strobe per oscillator edge |
| ratio_in | input | FB_W | Feedback divide ratio to load |
| ratio_load | input | 1 | Captures `ratio_in` as the pending ratio |
| lock_periods | input | LOCK_W | Good periods needed before `locked` rises |
| pulse_limit | input | PW_W | Largest `up`+`dn` width, in clocks, counted as good |
| ref_pulse | output | 1 | Reference divider terminal-count pulse |
| fb_pulse | output | 1 | Feedback divider terminal-count pulse |
| up | output | 1 | Raise oscillator frequency |
| dn | output | 1 | Lower oscillator frequency |
| locked | output | 1 | Lock indicator |

## Verification
The assertions assume that each strobe input is a true edge indication. A divider pulse must therefore follow a clock in which its strobe was high. The comparator outputs may only rise as a result of the matching divider pulse, and `up` and `dn` are never high together.

The bench keeps both strobes high or deliberately withholds them for a few clocks. This shifts the relative phase by a known amount. It holds the ratio at or above the reference ratio, so no divider ever emits back-to-back pulses.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic [1:0] {
    PFD_IDLE     = 2'd0,
    PFD_LEAD_REF = 2'd1,
    PFD_LEAD_FB  = 2'd2
  } pfd_state_e;

  function automatic int unsigned cnt_width(input int unsigned span);
    cnt_width = (span > 2) ? $clog2(span) : 1;
  endfunction
endpackage

// File: rtl/pfd_ref_div.sv
module pfd_ref_div #(
  parameter int unsigned REF_DIV = 300,
  localparam int unsigned CW = pfd_pkg::cnt_width(REF_DIV)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic pulse
);
  localparam logic [CW-1:0] TOP = CW'(REF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pulse_d;
  logic          at_zero;

  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (tick) begin
      if (at_zero) begin
        cnt_d   = TOP;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= TOP;
      pulse <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      pulse <= pulse_d;
    end
  end
endmodule

// File: rtl/pfd_fb_div.sv
module pfd_fb_div #(
  parameter int unsigned FB_W       = 14,
  parameter int unsigned FB_DEFAULT = 10000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic [FB_W-1:0] ratio_in,
  input  logic            ratio_load,
  output logic            pulse
);
  localparam logic [FB_W-1:0] DEF = FB_W'(FB_DEFAULT);

  logic [FB_W-1:0] cnt_q, cnt_d;
  logic [FB_W-1:0] pend_q, pend_d;
  logic            pend_v_q, pend_v_d;
  logic [FB_W-1:0] act_q, act_d;
  logic [FB_W-1:0] reload;
  logic            term;
  logic            pulse_d;

  assign term   = tick && (cnt_q == '0);
  assign reload = pend_v_q ? pend_q : act_q;

  always_comb begin
    cnt_d    = cnt_q;
    act_d    = act_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    pulse_d  = term;
    if (tick) begin
      if (term) begin
        cnt_d = (reload == '0) ? '0 : reload - 1'b1;
        act_d = reload;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    if (term) pend_v_d = 1'b0;
    if (ratio_load) begin
      pend_d   = ratio_in;
      pend_v_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= DEF - 1'b1;
      act_q    <= DEF;
      pend_q   <= DEF;
      pend_v_q <= 1'b0;
      pulse    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      act_q    <= act_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      pulse    <= pulse_d;
    end
  end
endmodule

// File: rtl/pfd_compare.sv
module pfd_compare (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ev,
  input  logic fb_ev,
  output logic up,
  output logic dn,
  output logic done
);
  import pfd_pkg::*;

  pfd_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    done = 1'b0;
    unique case (st_q)
      PFD_IDLE: begin
        if (ref_ev && fb_ev)  done = 1'b1;
        else if (ref_ev)      st_d = PFD_LEAD_REF;
        else if (fb_ev)       st_d = PFD_LEAD_FB;
      end
      PFD_LEAD_REF: begin
        if (fb_ev) begin
          st_d = PFD_IDLE;
          done = 1'b1;
        end
      end
      PFD_LEAD_FB: begin
        if (ref_ev) begin
          st_d = PFD_IDLE;
          done = 1'b1;
        end
      end
      default: st_d = PFD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PFD_IDLE;
    else        st_q <= st_d;
  end

  assign up = (st_q == PFD_LEAD_REF);
  assign dn = (st_q == PFD_LEAD_FB);
endmodule

// File: rtl/pfd_lock_det.sv
module pfd_lock_det #(
  parameter int unsigned LOCK_W = 8,
  parameter int unsigned PW_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              done,
  input  logic [LOCK_W-1:0] lock_periods,
  input  logic [PW_W-1:0]   pulse_limit,
  output logic              locked
);
  logic [PW_W-1:0]   wcnt_q, wcnt_d;
  logic [PW_W:0]     width;
  logic [LOCK_W-1:0] good_q, good_d, good_inc;
  logic              locked_d;
  logic              is_good;

  assign width    = {1'b0, wcnt_q} + {{PW_W{1'b0}}, active};
  assign is_good  = (width <= {1'b0, pulse_limit});
  assign good_inc = (good_q == '1) ? good_q : good_q + 1'b1;

  always_comb begin
    wcnt_d   = wcnt_q;
    good_d   = good_q;
    locked_d = locked;
    if (done) begin
      wcnt_d = '0;
      if (is_good) begin
        good_d   = good_inc;
        locked_d = (good_inc >= lock_periods);
      end else begin
        good_d   = '0;
        locked_d = 1'b0;
      end
    end else if (active && (wcnt_q != '1)) begin
      wcnt_d = wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      good_q <= '0;
      locked <= 1'b0;
    end else begin
      wcnt_q <= wcnt_d;
      good_q <= good_d;
      locked <= locked_d;
    end
  end
endmodule

// File: rtl/pfd_synth_core.sv
module pfd_synth_core #(
  parameter int unsigned REF_DIV    = 300,
  parameter int unsigned FB_W       = 14,
  parameter int unsigned FB_DEFAULT = 10000,
  parameter int unsigned LOCK_W     = 8,
  parameter int unsigned PW_W       = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              vco_tick,
  input  logic [FB_W-1:0]   ratio_in,
  input  logic              ratio_load,
  input  logic [LOCK_W-1:0] lock_periods,
  input  logic [PW_W-1:0]   pulse_limit,
  output logic              ref_pulse,
  output logic              fb_pulse,
  output logic              up,
  output logic              dn,
  output logic              locked
);
  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       cmp_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  pfd_ref_div #(.REF_DIV(REF_DIV)) u_ref_div (
    .clk   (clk),
    .rst_n (core_rst_n),
    .tick  (ref_tick),
    .pulse (ref_pulse)
  );

  pfd_fb_div #(.FB_W(FB_W), .FB_DEFAULT(FB_DEFAULT)) u_fb_div (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .tick       (vco_tick),
    .ratio_in   (ratio_in),
    .ratio_load (ratio_load),
    .pulse      (fb_pulse)
  );

  pfd_compare u_cmp (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .ref_ev (ref_pulse),
    .fb_ev  (fb_pulse),
    .up     (up),
    .dn     (dn),
    .done   (cmp_done)
  );

  pfd_lock_det #(.LOCK_W(LOCK_W), .PW_W(PW_W)) u_lock (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .active       (up | dn),
    .done         (cmp_done),
    .lock_periods (lock_periods),
    .pulse_limit  (pulse_limit),
    .locked       (locked)
  );
endmodule

// File: rtl/pfd_synth_checker.sv
module pfd_synth_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic vco_tick,
  input logic ref_pulse,
  input logic fb_pulse,
  input logic up,
  input logic dn
);
  // R5
  excl_updn_chk: assert property (@(posedge clk) disable iff (!rst_n) !(up && dn));
  // R10
  ref_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) ref_pulse |-> $past(ref_tick));
  // R3
  fb_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n) fb_pulse |-> $past(vco_tick));
  // R5
  up_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(up) |-> $past(ref_pulse));
  // R6
  dn_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(dn) |-> $past(fb_pulse));
  // R7
  tie_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_pulse && fb_pulse && !up && !dn) |=> (!up && !dn));
endmodule

bind pfd_synth_core pfd_synth_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_tick  (ref_tick),
  .vco_tick  (vco_tick),
  .ref_pulse (ref_pulse),
  .fb_pulse  (fb_pulse),
  .up        (up),
  .dn        (dn)
);

// File: tb/tb_pfd_synth_core.sv
module tb_pfd_synth_core;
  localparam int unsigned RDIV = 12;
  localparam int unsigned FBW  = 14;
  localparam int unsigned LW   = 8;
  localparam int unsigned PWW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b1;
  logic vco_tick = 1'b1;
  logic [FBW-1:0] ratio_in = '0;
  logic ratio_load = 1'b0;
  logic [LW-1:0] lock_periods = 8'd4;
  logic [PWW-1:0] pulse_limit = '0;
  logic ref_pulse, fb_pulse, up, dn, locked;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  pfd_synth_core #(.REF_DIV(RDIV), .FB_W(FBW), .FB_DEFAULT(RDIV),
                   .LOCK_W(LW), .PW_W(PWW)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .vco_tick(vco_tick),
    .ratio_in(ratio_in), .ratio_load(ratio_load), .lock_periods(lock_periods),
    .pulse_limit(pulse_limit), .ref_pulse(ref_pulse), .fb_pulse(fb_pulse),
    .up(up), .dn(dn), .locked(locked));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      finish_run();
    end
  end

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // clocks from one pulse to the next on the selected output
  task automatic period_of(input bit sel_fb, output int n);
    do @(negedge clk); while (!(sel_fb ? fb_pulse : ref_pulse));
    n = 0;
    do begin @(negedge clk); n++; end while (!(sel_fb ? fb_pulse : ref_pulse));
  endtask

  // width of up and dn over two comparison periods (after settling)
  task automatic widths(output int wu, output int wd);
    wu = 0; wd = 0;
    for (int i = 0; i < 2 * RDIV; i++) begin
      @(negedge clk);
      if (up) wu++;
      if (dn) wd++;
    end
  endtask

  task automatic t_reset();
    wait_cycles(3);
    check("R1 up", up, 0);
    check("R1 dn", dn, 0);
    check("R1 locked", locked, 0);
    check("R1 pulses", ref_pulse | fb_pulse, 0);
    @(negedge clk) rst_n = 1'b1;
    wait_cycles(2);
    check("R1 after release", up | dn | locked | ref_pulse | fb_pulse, 0);
  endtask

  task automatic t_periods();
    int n;
    period_of(1'b0, n);
    check("R2 ref period", n, RDIV);
    period_of(1'b1, n);
    check("R3 fb default period", n, RDIV);
  endtask

  task automatic t_aligned_lock();
    int wu, wd;
    widths(wu, wd);
    check("R7 aligned up width", wu, 0);
    check("R7 aligned dn width", wd, 0);
    wait_cycles(4 * RDIV);
    check("R8 locked aligned", locked, 1);
  endtask

  task automatic t_ref_leads();
    int wu, wd;
    vco_tick = 1'b0;
    wait_cycles(3);
    vco_tick = 1'b1;
    wait_cycles(2 * RDIV);
    widths(wu, wd);
    check("R5 up width lag3", wu, 6);
    check("R5 dn stays low", wd, 0);
    check("R9 unlocked", locked, 0);
    pulse_limit = 12'd3;
    wait_cycles(6 * RDIV);
    check("R8 locked at limit", locked, 1);
  endtask

  task automatic t_fb_leads();
    int wu, wd;
    ref_tick = 1'b0;
    wait_cycles(5);
    ref_tick = 1'b1;
    wait_cycles(2 * RDIV);
    widths(wu, wd);
    check("R6 dn width lead2", wd, 4);
    check("R6 up stays low", wu, 0);
    pulse_limit = 12'd1;
    wait_cycles(2 * RDIV);
    check("R9 unlocked over limit", locked, 0);
  endtask

  task automatic t_gated_ref();
    int n;
    n = 0;
    do begin @(negedge clk); ref_tick = ~ref_tick; end while (!ref_pulse);
    do begin @(negedge clk); ref_tick = ~ref_tick; n++; end while (!ref_pulse);
    check("R10 gated ref period", n, 2 * RDIV);
    ref_tick = 1'b1;
  endtask

  task automatic t_ratio_load();
    int n;
    do @(negedge clk); while (!fb_pulse);
    n = 0;
    for (int i = 0; i < 3; i++) begin @(negedge clk); n++; end
    ratio_in = 14'd15;
    ratio_load = 1'b1;
    @(negedge clk); n++;
    ratio_load = 1'b0;
    while (!fb_pulse) begin @(negedge clk); n++; end
    check("R4 interval in progress", n, RDIV);
    n = 0;
    do begin @(negedge clk); n++; end while (!fb_pulse);
    check("R4 new ratio interval", n, 15);
    period_of(1'b1, n);
    check("R3 loaded ratio steady", n, 15);
  endtask

  initial begin
    t_reset();
    t_periods();
    t_aligned_lock();
    t_ref_leads();
    t_fb_leads();
    t_gated_ref();
    t_ratio_load();
    finish_run();
  end
endmodule